// File: doc/BRIEF.md
# Multicycle Signed/Unsigned Multiply Unit

This block is the multiply unit of a 32-bit processor core. It accepts two register operands and a two-bit operation code on a start pulse. It then runs the operation for a fixed number of cycles, which depends on the operation, and writes the product into a pair of result registers. The full-width forms multiply 32 by 32 bits, signed or unsigned, and fill both the high and the low result register with the 64-bit product. The half-width forms multiply the low 16 bits of each operand, signed or unsigned, and write a 32-bit product into the low register only.

Along with the product the unit keeps four condition flags: negative, zero, overflow and carry. The width of the operation decides which of them change and which are kept. A one-cycle done pulse marks the cycle in which the result registers and the flags take their new values. While an operation runs, busy is high and further start pulses are dropped.

Top module: `mul_seq_unit`

## Requirements
- R1: Operation code bit 1 selects half width (1) or full width (0), and bit 0 selects unsigned (1) or signed (0). So 00 is signed 32x32, 01 is unsigned 32x32, 10 is signed 16x16 and 11 is unsigned 16x16. A full-width operation writes product bits 63..32 to res_hi and bits 31..0 to res_lo.
- R2: A half-width operation multiplies only bits 15..0 of each operand. It writes the 32-bit product to res_lo, and res_hi keeps its previous value.
- R3: The start input is sampled on a rising edge while the unit is idle. From then on, done is first seen high 5 clock cycles later for a full-width operation and 3 cycles later for a half-width one. Busy is high in every cycle from the sampling edge until done rises.
- R4: A start pulse while busy is high is ignored. The running operation finishes with its own operands and code, and no second done follows.
- R5: A full-width operation sets N to product bit 63 and sets Z when all 64 product bits are zero. It sets V when the product does not fit in 32 bits: for signed operations that is the signed range, for unsigned ones the unsigned range. C keeps its value.
- R6: A half-width operation sets N to product bit 31 and sets Z when the 32-bit product is zero. V and C keep their values.
- R7: Done is high for exactly one cycle per accepted start, in the cycle in which the new results and flags first appear. At all other times the results and flags hold.
- R8: A synchronous reset clears res_hi, res_lo and all four flags, drops busy and done, and abandons any running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | Operation code: bit 1 half width, bit 0 unsigned |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results and flags were just updated |
| res_hi | output | 32 | High result register |
| res_lo | output | 32 | Low result register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (never changed by a multiply) |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, latencies of 5 and 3 cycles, and the direct product form. With a 32-bit word, a 64-bit integer model in the bench can hold every full-width product exactly. The distinct latencies allow the cycle of done to be told apart for each width. Under these values the overflow edges can be reached directly: the most negative operand, a product of exactly 2^31, and unsigned operands at their maximum. The same holds for the case of a half-width operation after an overflowing full-width one, which shows that V and res_hi are preserved.

// File: rtl/mulu_pkg.sv
package mulu_pkg;

   typedef enum logic [1:0] {
      MOP_S_WIDE   = 2'b00,
      MOP_U_WIDE   = 2'b01,
      MOP_S_NARROW = 2'b10,
      MOP_U_NARROW = 2'b11
   } mop_e;

   function automatic logic mop_is_narrow(input logic [1:0] code);
      return code[1];
   endfunction

   function automatic logic mop_is_signed(input logic [1:0] code);
      return ~code[0];
   endfunction

   function automatic int unsigned lat_max(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/mulu_seq.sv
module mulu_seq #(
   parameter int unsigned LAT_WIDE   = 5,
   parameter int unsigned LAT_NARROW = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic narrow,
   output logic busy,
   output logic accept,
   output logic fire,
   output logic done
);
   localparam int unsigned LMAX = mulu_pkg::lat_max(LAT_WIDE, LAT_NARROW);
   localparam int unsigned CW   = $clog2(LMAX) + 1;
   localparam logic [CW-1:0] LOAD_W = CW'(LAT_WIDE - 1);
   localparam logic [CW-1:0] LOAD_N = CW'(LAT_NARROW - 1);

   logic [CW-1:0] cnt;

   assign accept = start & ~busy;
   assign fire   = busy & (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= fire;
         if (accept) begin
            busy <= 1'b1;
            cnt  <= narrow ? LOAD_N : LOAD_W;
         end else if (fire) begin
            busy <= 1'b0;
         end else if (busy) begin
            cnt  <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/mulu_core.sv
module mulu_core #(
   parameter int unsigned XLEN     = 32,
   parameter bit          MAG_FORM = 1'b0
) (
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   input  logic              sgn,
   input  logic              narrow,
   output logic [2*XLEN-1:0] prod
);
   localparam int unsigned HLEN = XLEN / 2;
   localparam int unsigned EXT  = XLEN + 1;
   localparam int unsigned PW   = 2 * XLEN;

   logic [EXT-1:0] ext_a, ext_b;

   always_comb begin
      if (narrow) begin
         ext_a = {{(EXT-HLEN){sgn & a[HLEN-1]}}, a[HLEN-1:0]};
         ext_b = {{(EXT-HLEN){sgn & b[HLEN-1]}}, b[HLEN-1:0]};
      end else begin
         ext_a = {sgn & a[XLEN-1], a};
         ext_b = {sgn & b[XLEN-1], b};
      end
   end

   generate
      if (MAG_FORM) begin : g_mag
         logic [XLEN-1:0] mag_a, mag_b;
         logic [PW-1:0]   prod_u;
         logic            neg;
         assign mag_a  = ext_a[EXT-1] ? (~ext_a[XLEN-1:0] + 1'b1) : ext_a[XLEN-1:0];
         assign mag_b  = ext_b[EXT-1] ? (~ext_b[XLEN-1:0] + 1'b1) : ext_b[XLEN-1:0];
         assign neg    = ext_a[EXT-1] ^ ext_b[EXT-1];
         assign prod_u = {{XLEN{1'b0}}, mag_a} * {{XLEN{1'b0}}, mag_b};
         assign prod   = neg ? (~prod_u + 1'b1) : prod_u;
      end else begin : g_direct
         logic signed [PW-1:0] wa, wb;
         assign wa   = {{(PW-EXT){ext_a[EXT-1]}}, ext_a};
         assign wb   = {{(PW-EXT){ext_b[EXT-1]}}, ext_b};
         assign prod = wa * wb;
      end
   endgenerate
endmodule

// File: rtl/mulu_flags.sv
module mulu_flags #(
   parameter int unsigned XLEN = 32
) (
   input  logic [2*XLEN-1:0] prod,
   input  logic              sgn,
   input  logic              narrow,
   input  logic              v_old,
   input  logic              c_old,
   output logic              n_new,
   output logic              z_new,
   output logic              v_new,
   output logic              c_new
);
   logic [XLEN:0]   top_s;
   logic [XLEN-1:0] top_u;
   logic            ovf;

   assign top_s = prod[2*XLEN-1:XLEN-1];
   assign top_u = prod[2*XLEN-1:XLEN];
   assign ovf   = sgn ? ~((&top_s) | ~(|top_s)) : (|top_u);

   always_comb begin
      c_new = c_old;
      if (narrow) begin
         n_new = prod[XLEN-1];
         z_new = ~(|prod[XLEN-1:0]);
         v_new = v_old;
      end else begin
         n_new = prod[2*XLEN-1];
         z_new = ~(|prod);
         v_new = ovf;
      end
   end
endmodule

// File: rtl/mul_seq_unit.sv
module mul_seq_unit #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned LAT_WIDE   = 5,
   parameter int unsigned LAT_NARROW = 3,
   parameter bit          MAG_FORM   = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic [1:0]      op,
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] res_hi,
   output logic [XLEN-1:0] res_lo,
   output logic            flag_n,
   output logic            flag_z,
   output logic            flag_v,
   output logic            flag_c
);
   localparam int unsigned PW = 2 * XLEN;

   generate
      if (XLEN < 4 || (XLEN % 2) != 0) begin : g_bad_xlen
         $error("mul_seq_unit: XLEN must be even and at least 4");
      end
      if (LAT_WIDE < 1 || LAT_NARROW < 1) begin : g_bad_lat
         $error("mul_seq_unit: latencies must be at least 1");
      end
   endgenerate

   logic            accept, fire;
   logic [XLEN-1:0] a_q, b_q;
   logic            narrow_q, sgn_q;
   logic [PW-1:0]   prod;
   logic            n_nx, z_nx, v_nx, c_nx;

   mulu_seq #(
      .LAT_WIDE  (LAT_WIDE),
      .LAT_NARROW(LAT_NARROW)
   ) u_seq (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .narrow(mulu_pkg::mop_is_narrow(op)),
      .busy  (busy),
      .accept(accept),
      .fire  (fire),
      .done  (done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q      <= '0;
         b_q      <= '0;
         narrow_q <= 1'b0;
         sgn_q    <= 1'b0;
      end else if (accept) begin
         a_q      <= opnd_a;
         b_q      <= opnd_b;
         narrow_q <= mulu_pkg::mop_is_narrow(op);
         sgn_q    <= mulu_pkg::mop_is_signed(op);
      end
   end

   mulu_core #(
      .XLEN    (XLEN),
      .MAG_FORM(MAG_FORM)
   ) u_core (
      .a     (a_q),
      .b     (b_q),
      .sgn   (sgn_q),
      .narrow(narrow_q),
      .prod  (prod)
   );

   mulu_flags #(
      .XLEN(XLEN)
   ) u_flags (
      .prod  (prod),
      .sgn   (sgn_q),
      .narrow(narrow_q),
      .v_old (flag_v),
      .c_old (flag_c),
      .n_new (n_nx),
      .z_new (z_nx),
      .v_new (v_nx),
      .c_new (c_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_hi <= '0;
         res_lo <= '0;
         flag_n <= 1'b0;
         flag_z <= 1'b0;
         flag_v <= 1'b0;
         flag_c <= 1'b0;
      end else if (fire) begin
         res_lo <= prod[XLEN-1:0];
         if (!narrow_q) res_hi <= prod[PW-1:XLEN];
         flag_n <= n_nx;
         flag_z <= z_nx;
         flag_v <= v_nx;
         flag_c <= c_nx;
      end
   end
endmodule

// File: rtl/mulu_chk.sv
module mulu_chk #(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic            narrow_q,
   input logic [XLEN-1:0] res_hi,
   input logic [XLEN-1:0] res_lo,
   input logic            flag_n,
   input logic            flag_z,
   input logic            flag_v,
   input logic            flag_c
);
   logic rst_d;
   always_ff @(posedge clk) rst_d <= rst;

   a_r7_done_single: assert property (@(posedge clk) disable iff (rst || rst_d)
      done |=> !done);

   a_r7_hold_quiet: assert property (@(posedge clk) disable iff (rst || rst_d)
      !done |-> ($stable(res_hi) && $stable(res_lo) && $stable({flag_n, flag_z, flag_v})));

   a_r5_c_kept: assert property (@(posedge clk) disable iff (rst || rst_d)
      $stable(flag_c));

   a_r2_hi_kept: assert property (@(posedge clk) disable iff (rst || rst_d)
      (done && narrow_q) |-> $stable(res_hi));

   a_r6_v_kept: assert property (@(posedge clk) disable iff (rst || rst_d)
      (done && narrow_q) |-> $stable(flag_v));

   a_r3_busy_ends: assert property (@(posedge clk) disable iff (rst || rst_d)
      done |-> (!busy && $past(busy)));

   a_r4_accept: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);

   a_r5_n_wide: assert property (@(posedge clk) disable iff (rst || rst_d)
      (done && !narrow_q) |-> (flag_n == res_hi[XLEN-1]));

   a_r6_n_half: assert property (@(posedge clk) disable iff (rst || rst_d)
      (done && narrow_q) |-> (flag_n == res_lo[XLEN-1]));

   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (!busy && !done && res_hi == '0 && res_lo == '0 &&
               !flag_n && !flag_z && !flag_v && !flag_c));
endmodule

bind mul_seq_unit mulu_chk #(.XLEN(XLEN)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .narrow_q(narrow_q),
   .res_hi  (res_hi),
   .res_lo  (res_lo),
   .flag_n  (flag_n),
   .flag_z  (flag_z),
   .flag_v  (flag_v),
   .flag_c  (flag_c)
);

// File: tb/tb_mul_seq_unit.sv
module tb_mul_seq_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [1:0]  op_i = 2'b00;
   logic [31:0] a_i = '0, b_i = '0;
   logic        busy, done, flag_n, flag_z, flag_v, flag_c;
   logic [31:0] res_hi, res_lo;

   int checks = 0;
   int errors = 0;

   logic [31:0] e_hi = '0, e_lo = '0;
   logic        e_n = 1'b0, e_z = 1'b0, e_v = 1'b0;

   always #2.5 clk = ~clk;

   mul_seq_unit dut (
      .clk(clk), .rst(rst), .start(start), .op(op_i),
      .opnd_a(a_i), .opnd_b(b_i), .busy(busy), .done(done),
      .res_hi(res_hi), .res_lo(res_lo),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
      longint p;
      if (op[1]) begin
         if (op[0]) p = longint'({16'h0, a[15:0]}) * longint'({16'h0, b[15:0]});
         else       p = longint'(signed'(a[15:0])) * longint'(signed'(b[15:0]));
         e_lo = p[31:0];
         e_n  = p[31];
         e_z  = (p[31:0] == 32'h0);
      end else begin
         if (op[0]) p = longint'({32'h0, a}) * longint'({32'h0, b});
         else       p = longint'(signed'(a)) * longint'(signed'(b));
         e_hi = p[63:32];
         e_lo = p[31:0];
         e_n  = p[63];
         e_z  = (p == 64'h0);
         if (op[0]) e_v = (p[63:32] != 32'h0);
         else       e_v = !((p[63:31] == 33'h0) || (p[63:31] == {33{1'b1}}));
      end
   endtask

   // one scenario run: launch, time done, compare against model, watch for extra pulses
   task automatic do_op(input string tag, input logic [1:0] op,
                        input logic [31:0] a, input logic [31:0] b, input bit poke);
      int lat = op[1] ? 3 : 5;
      int seen = -1;
      int busy_low = 0;
      int extra = 0;
      @(negedge clk);
      start = 1'b1; op_i = op; a_i = a; b_i = b;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         start = 1'b1; op_i = ~op; a_i = 32'hDEAD_BEEF; b_i = 32'h7654_3210;
      end
      for (int j = 0; j < 20; j++) begin
         if (done) begin seen = j; break; end
         if (!busy) busy_low++;
         @(negedge clk);
         start = 1'b0;
      end
      start = 1'b0;
      model(op, a, b);
      chk({tag, " R3 done latency"}, 64'(seen), 64'(lat));
      chk({tag, " R3 busy while running"}, 64'(busy_low), 64'd0);
      chk({tag, " R1 R2 res_hi"}, {32'h0, res_hi}, {32'h0, e_hi});
      chk({tag, " R1 R2 res_lo"}, {32'h0, res_lo}, {32'h0, e_lo});
      chk({tag, " R5 R6 flag_n"}, {63'h0, flag_n}, {63'h0, e_n});
      chk({tag, " R5 R6 flag_z"}, {63'h0, flag_z}, {63'h0, e_z});
      chk({tag, " R5 R6 flag_v"}, {63'h0, flag_v}, {63'h0, e_v});
      chk({tag, " R5 R6 flag_c"}, {63'h0, flag_c}, 64'h0);
      for (int j = 0; j < 7; j++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk({tag, " R7 R4 single done"}, 64'(extra), 64'd0);
      chk({tag, " R7 hold lo"}, {32'h0, res_lo}, {32'h0, e_lo});
   endtask

   task automatic t_reset_state;
      chk("R8 reset busy", {63'h0, busy}, 64'h0);
      chk("R8 reset done", {63'h0, done}, 64'h0);
      chk("R8 reset results", {res_hi, res_lo}, 64'h0);
      chk("R8 reset flags", {60'h0, flag_n, flag_z, flag_v, flag_c}, 64'h0);
   endtask

   task automatic t_wide;
      do_op("R1 signed mixed", 2'b00, 32'hFFFF_FFFD, 32'h0000_0007, 1'b0);
      do_op("R1 unsigned max", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      do_op("R5 signed no ovf", 2'b00, 32'h0000_1234, 32'h0000_0100, 1'b0);
      do_op("R5 signed 2^31 ovf", 2'b00, 32'h0001_0000, 32'h0000_8000, 1'b0);
      do_op("R5 signed min x -1", 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
      do_op("R5 signed min x 1", 2'b00, 32'h8000_0000, 32'h0000_0001, 1'b0);
      do_op("R5 unsigned fits", 2'b01, 32'h0000_FFFF, 32'h0001_0001, 1'b0);
      do_op("R5 zero", 2'b01, 32'h0000_0000, 32'h9876_5432, 1'b0);
   endtask

   task automatic t_half;
      do_op("R5 set ovf first", 2'b01, 32'h8000_0000, 32'h0000_0004, 1'b0);
      do_op("R2 R6 signed neg", 2'b10, 32'hABCD_FFFE, 32'h5555_0003, 1'b0);
      do_op("R2 R6 unsigned", 2'b11, 32'h1234_FFFF, 32'hFFFF_FFFF, 1'b0);
      do_op("R2 R6 zero", 2'b10, 32'h7777_0000, 32'h0000_8000, 1'b0);
      do_op("R2 R6 min sq", 2'b10, 32'h0000_8000, 32'h0000_8000, 1'b0);
   endtask

   task automatic t_busy_start;
      do_op("R4 poke during wide", 2'b00, 32'h0000_0003, 32'hFFFF_FFF0, 1'b1);
      do_op("R4 poke during half", 2'b11, 32'h0000_0101, 32'h0000_0202, 1'b1);
   endtask

   task automatic t_reset_mid;
      int extra = 0;
      do_op("R8 prep", 2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0);
      @(negedge clk);
      start = 1'b1; op_i = 2'b01; a_i = 32'hFFFF_0000; b_i = 32'h0000_FFFF;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      for (int j = 0; j < 8; j++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk("R8 abandoned op gives no done", 64'(extra), 64'd0);
      chk("R8 results stay clear", {res_hi, res_lo}, 64'h0);
      e_hi = '0; e_lo = '0; e_n = 1'b0; e_z = 1'b0; e_v = 1'b0;
      do_op("R8 after reset", 2'b10, 32'h0000_0010, 32'h0000_0020, 1'b0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            t_reset_state();
            t_wide();
            t_half();
            t_busy_start();
            t_reset_mid();
         end
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule